// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits between the bus-access arbiter and the command pins of two SDRAM chip-select regions. A free-running interval counter raises a refresh request that stays pending until it is served. When a request is pending the sequencer stops granting accesses. It closes every open bank with a precharge-all, then sends an auto-refresh to both regions at once. It then holds off any activate until a programmable row-cycle gap has passed.

Accesses arrive through a valid/ready handshake. A granted access issues an activate on the selected region. After a programmable activate-to-column delay it raises a one-cycle column strobe, and the downstream column logic acts on that strobe. A level control input moves the memory into low-power self-refresh: precharge-all, then the self-refresh command with clock-enable low. Dropping the input raises clock-enable again. The exit is then followed by the same row-cycle wait before any new command. Commands are combinational decodes of the sequencer state on active-low RAS, CAS, WE and chip-select pins.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During and right after reset the pins carry NOP (sdCsN=11, RAS/CAS/WE high), sdCke is high and colStart is low. accReady is high in the first cycle after release when lowPowerEn is low.
- R2: With no accesses and no self-refresh, REF commands repeat every refPeriod+1 cycles (refPeriod of 2 or more), and a raised request stays pending until a REF or SELF serves it.
- R3: Every REF (sdCsN=00, RAS low, CAS low, WE high, sdCke high) comes in the cycle right after a PALL (sdCsN=00, RAS low, CAS high, WE low).
- R4: No ACTV (RAS low, CAS high, WE high) is issued earlier than rowCycle cycles after the latest REF.
- R5: With accValid held through a refresh, the next ACTV lands exactly rowCycle cycles after the REF (rowCycle of 3 or more). Back-to-back accesses with no refresh between them issue ACTV every max(rcdCycles,2)+2 cycles.
- R6: A handshake (accValid and accReady high at a clock edge) gives an ACTV in the next cycle with only the chosen region selected: accCs=0 gives sdCsN=10, accCs=1 gives sdCsN=01.
- R7: colStart is a one-cycle pulse exactly max(rcdCycles,2) cycles after the ACTV.
- R8: lowPowerEn seen high in an idle cycle gives a PALL in the next cycle and a SELF (REF pin pattern with sdCke low) in the cycle after that.
- R9: While sdCke stays low after SELF, only NOP is driven, no REF is issued and accReady stays low.
- R10: When lowPowerEn is cleared, sdCke rises in a NOP cycle (the exit). No non-NOP command comes earlier than rowCycle cycles after it, and a waiting access gets its ACTV exactly rowCycle cycles after it (rowCycle of 3 or more).
- R11: accReady is high only in cycles from which an ACTV in the next cycle is legal: the refresh or exit gap has elapsed and the previous access has reached its column strobe.
- R12: accReady is low in the cycle before every PALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refPeriod | input | PERIOD_W | Refresh interval minus one, in cycles |
| rowCycle | input | TIME_W | Row-cycle gap after REF or self-refresh exit, in cycles |
| rcdCycles | input | TIME_W | Activate-to-column delay, in cycles |
| lowPowerEn | input | 1 | High requests self-refresh, low requests exit |
| accValid | input | 1 | Access request valid |
| accCs | input | 1 | Region of the requested access |
| accReady | output | 1 | Access can be accepted this cycle |
| colStart | output | 1 | One-cycle strobe that starts the column phase |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 2 | Active-low chip selects, bit i for region i |
| sdRasN | output | 1 | Active-low row strobe |
| sdCasN | output | 1 | Active-low column strobe |
| sdWeN | output | 1 | Active-low write enable |

## Verification
Two things can fall in the same cycle: a refresh request rising and an access waiting for its grant. The bench provokes this by holding accValid high without a break through many refresh intervals, with random region choices. It judges the result from the pins: accReady must be low in the cycle before each PALL, and the held access must reach ACTV exactly rowCycle cycles after the REF. The same collision is provoked with self-refresh exit by dropping lowPowerEn and raising accValid in the same cycle, and the ACTV must then fall exactly rowCycle cycles after the exit.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Strobes from the sequencer control to the counter datapath
  typedef struct packed {
    logic loadGap;     // start the row-cycle wait
    logic loadRcd;     // start the activate-to-column wait
    logic refIssued;   // a REF or SELF has served the pending request
    logic selfActive;  // interval requests are dropped
  } seqStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PALL, ST_REF, ST_GAP, ST_ACT, ST_RCD, ST_COL,
    ST_SPALL, ST_SELF, ST_SLEEP, ST_SXIT
  } seqState_t;

endpackage

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int PERIOD_W = 12,
  parameter int TIME_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] refPeriod,
  input  logic [TIME_W-1:0]   rowCycle,
  input  logic [TIME_W-1:0]   rcdCycles,
  input  seqStrobe_t          strobe,
  output logic                refPending,
  output logic                timerLow
);

  localparam logic [PERIOD_W-1:0] TickAt  = PERIOD_W'(1);
  localparam logic [TIME_W-1:0]   GapTrim = TIME_W'(2);
  localparam logic [TIME_W-1:0]   RcdTrim = TIME_W'(1);

  logic [PERIOD_W-1:0] intervalCnt;
  logic [TIME_W-1:0]   stepTimer;
  logic                tick;

  assign tick = (intervalCnt == TickAt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (intervalCnt == '0) begin
      intervalCnt <= refPeriod;
    end else begin
      intervalCnt <= intervalCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPending <= 1'b0;
    end else if (tick && !strobe.selfActive) begin
      refPending <= 1'b1;
    end else if (strobe.refIssued) begin
      refPending <= 1'b0;
    end
  end

  // One down-counter serves every timed step; the loads are trimmed so that
  // the control leaves its wait state when the count reaches one or less.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepTimer <= '0;
    end else if (strobe.loadGap) begin
      stepTimer <= (rowCycle > GapTrim) ? rowCycle - GapTrim : '0;
    end else if (strobe.loadRcd) begin
      stepTimer <= (rcdCycles > RcdTrim) ? rcdCycles - RcdTrim : '0;
    end else if (stepTimer != '0) begin
      stepTimer <= stepTimer - 1'b1;
    end
  end

  assign timerLow = (stepTimer <= TIME_W'(1));

  // R2: a raised request is only withdrawn by a REF or SELF
  p_pending_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(refPending) && !refPending) |-> $past(strobe.refIssued));

  // R4: the step timer never wraps while counting down
  p_timer_no_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stepTimer) == '0 && !$past(strobe.loadGap) && !$past(strobe.loadRcd))
      |-> (stepTimer == '0));

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowPowerEn,
  input  logic       accValid,
  input  logic       accCs,
  input  logic       refPending,
  input  logic       timerLow,
  output seqStrobe_t strobe,
  output logic       accReady,
  output logic       colStart,
  output logic       sdCke,
  output logic [1:0] sdCsN,
  output logic       sdRasN,
  output logic       sdCasN,
  output logic       sdWeN
);

  seqState_t state, nextState;
  logic      csSel;
  logic      grant;

  assign accReady = (state == ST_IDLE) && !lowPowerEn && !refPending;
  assign grant    = accReady && accValid;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (lowPowerEn)      nextState = ST_SPALL;
        else if (refPending) nextState = ST_PALL;
        else if (accValid)   nextState = ST_ACT;
      end
      ST_PALL:  nextState = ST_REF;
      ST_REF:   nextState = ST_GAP;
      ST_GAP:   if (timerLow) nextState = ST_IDLE;
      ST_ACT:   nextState = ST_RCD;
      ST_RCD:   if (timerLow) nextState = ST_COL;
      ST_COL:   nextState = ST_IDLE;
      ST_SPALL: nextState = ST_SELF;
      ST_SELF:  nextState = ST_SLEEP;
      ST_SLEEP: if (!lowPowerEn) nextState = ST_SXIT;
      ST_SXIT:  nextState = ST_GAP;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      csSel <= 1'b0;
    end else begin
      state <= nextState;
      if (grant) csSel <= accCs;
    end
  end

  always_comb begin
    strobe.loadGap    = (state == ST_REF) || (state == ST_SXIT);
    strobe.loadRcd    = (state == ST_ACT);
    strobe.refIssued  = (state == ST_REF) || (state == ST_SELF);
    strobe.selfActive = (state == ST_SELF) || (state == ST_SLEEP) || (state == ST_SXIT);
  end

  // Pin decode: active-low RAS/CAS/WE/CS, NOP has nothing asserted
  always_comb begin
    sdCsN    = 2'b11;
    sdRasN   = 1'b1;
    sdCasN   = 1'b1;
    sdWeN    = 1'b1;
    sdCke    = 1'b1;
    colStart = 1'b0;
    unique case (state)
      ST_PALL, ST_SPALL: begin
        sdCsN = 2'b00; sdRasN = 1'b0; sdWeN = 1'b0;
      end
      ST_REF: begin
        sdCsN = 2'b00; sdRasN = 1'b0; sdCasN = 1'b0;
      end
      ST_SELF: begin
        sdCsN = 2'b00; sdRasN = 1'b0; sdCasN = 1'b0; sdCke = 1'b0;
      end
      ST_SLEEP: sdCke = 1'b0;
      ST_ACT: begin
        sdCsN  = csSel ? 2'b01 : 2'b10;
        sdRasN = 1'b0;
      end
      ST_COL:  colStart = 1'b1;
      default: ;
    endcase
  end

  p_pall_before_ref_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && !sdCasN && sdWeN && sdCke)
      |-> ($past(!sdRasN) && $past(sdCasN) && $past(!sdWeN)));

  p_ref_both_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && !sdCasN) |-> (sdCsN == 2'b00));

  p_act_one_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && sdCasN && sdWeN) |-> ($countones(sdCsN) == 1));

  p_grant_act_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accReady) |=> (!sdRasN && sdCasN && sdWeN));

  p_col_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    colStart |=> !colStart);

  p_sleep_nop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCke && $past(!sdCke)) |-> (sdRasN && sdCasN && sdWeN && !accReady));

  p_ready_pending_r12: assert property (@(posedge clk) disable iff (!rstN)
    accReady |-> !refPending);

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int PERIOD_W = 12,
  parameter int TIME_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] refPeriod,
  input  logic [TIME_W-1:0]   rowCycle,
  input  logic [TIME_W-1:0]   rcdCycles,
  input  logic                lowPowerEn,
  input  logic                accValid,
  input  logic                accCs,
  output logic                accReady,
  output logic                colStart,
  output logic                sdCke,
  output logic [1:0]          sdCsN,
  output logic                sdRasN,
  output logic                sdCasN,
  output logic                sdWeN
);

  seqStrobe_t strobe;
  logic       refPending;
  logic       timerLow;

  sdram_seq_dp #(
    .PERIOD_W(PERIOD_W),
    .TIME_W  (TIME_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .refPeriod (refPeriod),
    .rowCycle  (rowCycle),
    .rcdCycles (rcdCycles),
    .strobe    (strobe),
    .refPending(refPending),
    .timerLow  (timerLow)
  );

  sdram_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lowPowerEn(lowPowerEn),
    .accValid  (accValid),
    .accCs     (accCs),
    .refPending(refPending),
    .timerLow  (timerLow),
    .strobe    (strobe),
    .accReady  (accReady),
    .colStart  (colStart),
    .sdCke     (sdCke),
    .sdCsN     (sdCsN),
    .sdRasN    (sdRasN),
    .sdCasN    (sdCasN),
    .sdWeN     (sdWeN)
  );

endmodule

// File: tb/tb_sdram_refresh_seq.sv
`timescale 1ns/1ps
module tb_sdram_refresh_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] refPeriod = 12'd40;
  logic [3:0]  rowCycle = 4'd6;
  logic [3:0]  rcdCycles = 4'd2;
  logic        lowPowerEn = 1'b0;
  logic        accValid = 1'b0;
  logic        accCs = 1'b0;
  logic        accReady, colStart, sdCke, sdRasN, sdCasN, sdWeN;
  logic [1:0]  sdCsN;

  sdram_refresh_seq dut (
    .clk(clk), .rstN(rstN), .refPeriod(refPeriod), .rowCycle(rowCycle),
    .rcdCycles(rcdCycles), .lowPowerEn(lowPowerEn), .accValid(accValid),
    .accCs(accCs), .accReady(accReady), .colStart(colStart), .sdCke(sdCke),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, failures = 0, cyc = 0;
  int P, R, CD;
  int lastRef, lastAct, lastPall, lastSelf, lastSelfx, grantCyc, refCnt;
  bit expCs, prevPall, prevCke, prevReady, monOn = 0, spacingOn = 0, strict = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic int colDelay(int d);
    return (d < 2) ? 2 : d;
  endfunction

  // Monitor: samples 1 ns after each falling edge
  always begin
    @(negedge clk);
    #1;
    if (rstN && monOn) begin
      bit isNop, isPall, isRef, isSelf, isAct;
      isNop  = sdRasN && sdCasN && sdWeN;
      isPall = (sdCsN == 2'b00) && !sdRasN && sdCasN && !sdWeN && sdCke;
      isRef  = (sdCsN == 2'b00) && !sdRasN && !sdCasN && sdWeN && sdCke;
      isSelf = (sdCsN == 2'b00) && !sdRasN && !sdCasN && sdWeN && !sdCke;
      isAct  = !sdRasN && sdCasN && sdWeN;
      if (isRef) begin
        chk(prevPall, "R3 PALL before REF", 0, 1);
        if (spacingOn && lastRef > -1000) chk(cyc - lastRef == P + 1, "R2 spacing", cyc - lastRef, P + 1);
        lastRef = cyc; refCnt++;
      end
      if (isPall) begin
        chk(!prevReady, "R12 ready before PALL", prevReady, 0);
        lastPall = cyc;
      end
      if (isAct) begin
        chk(cyc - lastRef >= R, "R4 gap", cyc - lastRef, R);
        chk(cyc - lastSelfx >= R, "R10 exit gap", cyc - lastSelfx, R);
        chk(cyc == grantCyc + 1, "R6 ACTV after grant", cyc, grantCyc + 1);
        chk(sdCsN == (expCs ? 2'b01 : 2'b10), "R6 chip select", sdCsN, expCs ? 1 : 2);
        if (strict) begin
          if (lastRef > lastAct && lastRef > lastSelfx)
            chk(cyc - lastRef == R, "R5 held access", cyc - lastRef, R);
          else if (lastSelfx > lastAct && lastSelfx > lastRef)
            chk(cyc - lastSelfx == R, "R10 held access", cyc - lastSelfx, R);
          else if (lastAct > -1000)
            chk(cyc - lastAct == CD + 2, "R5 back-to-back", cyc - lastAct, CD + 2);
        end
        lastAct = cyc;
      end
      if (colStart) chk(cyc - lastAct == CD, "R7 column delay", cyc - lastAct, CD);
      if (!sdCke) begin
        chk(!accReady, "R9 ready in self-refresh", accReady, 0);
        if (prevCke) begin
          chk(isSelf && prevPall, "R8 SELF after PALL", isSelf, 1);
          lastSelf = cyc;
        end else chk(isNop, "R9 NOP in self-refresh", isNop, 1);
      end
      if (sdCke && !prevCke) begin
        lastSelfx = cyc;
        chk(isNop, "R10 exit is NOP", isNop, 1);
      end
      if (sdCke && !isNop) chk(cyc - lastSelfx >= R, "R10 quiet after exit", cyc - lastSelfx, R);
      if (accReady) begin
        chk(cyc + 1 - lastRef >= R, "R11 ready vs REF gap", cyc + 1 - lastRef, R);
        chk(cyc >= lastAct + CD + 1, "R11 ready vs access", cyc, lastAct + CD + 1);
      end
      if (accValid && accReady) begin
        grantCyc = cyc; expCs = accCs;
      end
      prevPall = isPall; prevCke = sdCke; prevReady = accReady;
    end
  end

  task automatic doReset(int p, int r, int d);
    @(negedge clk);
    monOn = 0; rstN = 0; accValid = 0; lowPowerEn = 0;
    P = p; R = r; CD = colDelay(d);
    refPeriod = 12'(p); rowCycle = 4'(r); rcdCycles = 4'(d);
    repeat (3) @(negedge clk);
    chk(sdCsN == 2'b11 && sdRasN && sdCasN && sdWeN, "R1 NOP in reset", {sdCsN, sdRasN, sdCasN, sdWeN}, 31);
    chk(sdCke && !colStart, "R1 cke/col in reset", {sdCke, colStart}, 2);
    lastRef = -1000; lastAct = -1000; lastPall = -1000; lastSelf = -1000;
    lastSelfx = -1000; grantCyc = -1000; refCnt = 0;
    prevPall = 0; prevCke = 1; prevReady = 0;
    rstN = 1;
    #1;
    chk(accReady && sdCke && sdRasN, "R1 ready after reset", accReady, 1);
    monOn = 1;
    @(negedge clk);
  endtask

  task automatic stream(int n);
    int got = 0;
    strict = 1; accValid = 1; accCs = 1'($urandom);
    while (got < n) begin
      bit g;
      #1;
      g = accValid && accReady;
      @(negedge clk);
      if (g) begin
        got++;
        accCs = 1'($urandom);
      end
    end
    accValid = 0; strict = 0;
  endtask

  task automatic selfTest(int holdCycles);
    int setCyc, refsBefore;
    while (refCnt == 0) @(negedge clk);
    refsBefore = refCnt;
    while (refCnt == refsBefore) @(negedge clk);
    repeat (R + 2) @(negedge clk);
    setCyc = cyc; lowPowerEn = 1;
    repeat (4) @(negedge clk);
    chk(lastPall == setCyc + 1, "R8 PALL timing", lastPall, setCyc + 1);
    chk(lastSelf == setCyc + 2, "R8 SELF timing", lastSelf, setCyc + 2);
    refsBefore = refCnt;
    repeat (holdCycles) @(negedge clk);
    chk(refCnt == refsBefore, "R9 no REF while asleep", refCnt, refsBefore);
    chk(!sdCke, "R8 cke held low", sdCke, 0);
    lowPowerEn = 0;
    stream(6);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // Phase 1: refresh interval and sequence with no traffic
    doReset(40, 6, 2);
    spacingOn = 1;
    while (refCnt < 4) @(negedge clk);
    spacingOn = 0;
    chk(refCnt == 4, "R2 refresh count", refCnt, 4);
    // Phase 2: held accesses colliding with refresh
    stream(40);
    // Phase 3: self-refresh entry, stay, exit with waiting access
    selfTest(3 * P);
    // Phase 4: other timing set
    doReset(30, 3, 5);
    stream(30);
    selfTest(100);
    // Phase 5: random traffic and power requests
    doReset(60, 5, 1);
    begin
      bit granted = 0;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        if (granted || !accValid) begin
          accValid = ($urandom % 3 == 0);
          accCs = 1'($urandom);
        end
        if ($urandom % 150 == 0) lowPowerEn = ~lowPowerEn;
        #1;
        granted = accValid && accReady;
      end
      @(negedge clk);
      accValid = 0; lowPowerEn = 0;
    end
    repeat (80) @(negedge clk);
    chk(refCnt > 10, "R2 refresh under traffic", refCnt, 11);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule